// File: doc/BRIEF.md
# Stipple and Block-Copy Pixel Engine

This block is a small drawing accelerator for a frame store that keeps one byte per pixel. It owns a private pixel memory of `2**PIX_AW` bytes and is driven by 32-bit bus writes. The bus address does three jobs. Its top bit picks the engine window. Bits 22:3 carry the destination pixel. Bit 2 says whether the write loads the drawing color or starts an operation.

There are two windows. The mask window (address bit 23 = 0) paints the held color into up to 32 consecutive pixels, chosen by a bit mask. The block window (address bit 23 = 1) either copies a run of 1 to 32 pixels from a source pixel address, or fills the run with the color.

An operation handles one pixel per clock. While it runs, `busy` is high and further bus writes are held off with `bus_ready` low. A combinational debug read port exposes any pixel so the memory contents can be inspected.

Top module: `pix_engine`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0, `bus_ready` is 1 and the held drawing color is 0. The pixel memory itself is not cleared by reset.
- R2: An accepted write with address bit 2 = 0 loads `bus_wdata[7:0]` as the drawing color. Data bits 31:8 are ignored. The color stays unchanged until the next such write.
- R3: An accepted write with address bit 2 = 1 starts an operation. The destination pixel is `bus_addr[22:3]`. Address bit 23 selects the window: 0 for mask painting, 1 for block operations.
- R4: In mask painting, data bit 31 governs destination+0, and in general bit 31-i governs destination+i. A 1 bit writes the color to that pixel. A 0 bit leaves the pixel as it was.
- R5: In a block operation, `bus_wdata[23:0]` is the source pixel address and the run length is `bus_wdata[28:24]`+1. When the source is not all ones, the run is copied from the source to the destination.
- R6: In a block operation whose source field is 0xFFFFFF, every pixel of the run starting at the destination is set to the color.
- R7: A copy moves pixels in ascending address order. When the destination overlaps the source from above, pixels already written are read again as sources.
- R8: An operation keeps `busy` high for exactly as many cycles as its length: 32 for mask painting, and the run length for block operations. While `busy` is high, `bus_ready` is low for writes, and a waiting write is accepted once the operation ends.
- R9: Bus reads are always ready, return 0 and have no effect on the color, the memory or `busy`.
- R10: Destination and source pixel addresses, including the addresses stepped through during an operation, wrap modulo the memory depth `2**PIX_AW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Byte address: bit 23 window, bits 22:3 pixel, bit 2 color/launch |
| bus_wdata | input | 32 | Write data: color, mask or block command |
| bus_ready | output | 1 | Access accepted on this edge when high |
| bus_rdata | output | 32 | Read data, always 0 |
| busy | output | 1 | Operation in progress |
| dbg_addr | input | PIX_AW | Debug pixel address |
| dbg_pix | output | 8 | Pixel at `dbg_addr` |

## Verification
The hardest case to reach from the ports is a write that arrives while an operation is running. To create it, the bench launches a 32-cycle mask operation and raises a color write on the very next cycle. It then checks that `bus_ready` is low, waits for the write to be accepted, and uses a one-pixel fill to prove which color was actually taken.

Overlapping copies and address wrap are reached through a reference model in the bench. The model replays every operation pixel by pixel in ascending order, and after each operation the bench compares the whole memory against it through the debug port.

// File: rtl/pe_pkg.sv
// Shared constants and types for the pixel engine.
// Assumes a fixed 24-bit byte address bus and a 32-bit data bus.
package pe_pkg;
    localparam int BUS_AW   = 24;   // byte address width
    localparam int DATA_W   = 32;   // bus data width
    localparam int LEN_W    = 5;    // run length field width
    localparam int SPAN     = 32;   // widest operation in pixels
    localparam int SRC_W    = 24;   // block command source field width
    localparam int WIN_BIT  = 23;   // window select bit
    localparam int GO_BIT   = 2;    // color (0) / launch (1) select bit
    localparam int DST_LSB  = 3;    // lowest destination bit in the address
    localparam logic [SRC_W-1:0] FILL_CODE = '1;

    // Operation kinds carried from decode to the sequencer.
    typedef enum logic [1:0] {
        OP_MASK = 2'd0,
        OP_COPY = 2'd1,
        OP_FILL = 2'd2
    } pe_op_e;
endpackage

// File: rtl/pe_pixel_ram.sv
// Byte-wide pixel store: one synchronous write port, two combinational
// read ports (copy source and debug). Contents are not reset.
// Assumes the depth is a power of two given as an address width.
module pe_pixel_ram #(
    parameter int PIX_AW = 10,
    parameter int PIX_W  = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PIX_AW-1:0] wr_addr,
    input  logic [PIX_W-1:0]  wr_data,
    input  logic [PIX_AW-1:0] rd_a_addr,
    output logic [PIX_W-1:0]  rd_a_data,
    input  logic [PIX_AW-1:0] rd_b_addr,
    output logic [PIX_W-1:0]  rd_b_data
);
    localparam int DEPTH = 1 << PIX_AW;

    logic [PIX_W-1:0] mem [DEPTH];

    // Store one pixel per cycle when enabled.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Both read ports are plain asynchronous lookups.
    assign rd_a_data = mem[rd_a_addr];
    assign rd_b_data = mem[rd_b_addr];
endmodule

// File: rtl/pe_decode.sv
// Bus write decoder: holds the drawing color and turns a launch write into
// an operation descriptor. Assumes `accept` is high only for a write that
// is being taken on this edge.
module pe_decode
    import pe_pkg::*;
#(
    parameter int PIX_AW = 10,
    parameter int PIX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [PIX_W-1:0]  color,
    output logic              start,
    output pe_op_e            op,
    output logic [PIX_AW-1:0] dst,
    output logic [PIX_AW-1:0] src,
    output logic [LEN_W-1:0]  len_m1,
    output logic [SPAN-1:0]   mask
);
    logic is_block;
    logic unused_bits;

    // Hold the drawing color; only a color write changes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            color <= '0;
        end else if (accept && !bus_addr[GO_BIT]) begin
            color <= bus_wdata[PIX_W-1:0];
        end
    end

    // Build the descriptor of the operation a launch write requests.
    always_comb begin
        is_block = bus_addr[WIN_BIT];
        start    = accept && bus_addr[GO_BIT];
        dst      = bus_addr[DST_LSB +: PIX_AW];
        src      = bus_wdata[PIX_AW-1:0];
        if (!is_block) begin
            op     = OP_MASK;
            len_m1 = LEN_W'(SPAN - 1);
            mask   = bus_wdata;
        end else begin
            op     = (bus_wdata[SRC_W-1:0] == FILL_CODE) ? OP_FILL : OP_COPY;
            len_m1 = bus_wdata[SRC_W +: LEN_W];
            mask   = '1;
        end
    end

    assign unused_bits = ^{bus_addr, bus_wdata};

    // R2: the color only moves on an accepted color write.
    a_r2_color_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && !bus_addr[GO_BIT]) |=> $stable(color));
endmodule

// File: rtl/pe_sequencer.sv
// Steps an operation one pixel per cycle in ascending order, producing the
// write port controls and the copy source address. Assumes `start` is only
// raised while idle.
module pe_sequencer
    import pe_pkg::*;
#(
    parameter int PIX_AW = 10,
    parameter int PIX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  pe_op_e            op,
    input  logic [PIX_AW-1:0] dst,
    input  logic [PIX_AW-1:0] src,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [SPAN-1:0]   mask,
    input  logic [PIX_W-1:0]  color,
    input  logic [PIX_W-1:0]  src_pix,
    output logic              busy,
    output logic              wr_en,
    output logic [PIX_AW-1:0] wr_addr,
    output logic [PIX_W-1:0]  wr_data,
    output logic [PIX_AW-1:0] src_addr
);
    pe_op_e            op_q;
    logic [PIX_AW-1:0] dst_q;
    logic [PIX_AW-1:0] src_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [SPAN-1:0]   mask_q;
    logic              busy_q;

    // Load a new operation when idle, otherwise advance the running one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            op_q   <= OP_MASK;
            dst_q  <= '0;
            src_q  <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
            mask_q <= '0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q + 1'b1;
            mask_q <= mask_q << 1;
            if (cnt_q == len_q) begin
                busy_q <= 1'b0;
            end
        end else if (start) begin
            busy_q <= 1'b1;
            op_q   <= op;
            dst_q  <= dst;
            src_q  <= src;
            len_q  <= len_m1;
            cnt_q  <= '0;
            mask_q <= mask;
        end
    end

    // Address arithmetic wraps naturally at the memory depth.
    always_comb begin
        wr_addr  = dst_q + PIX_AW'(cnt_q);
        src_addr = src_q + PIX_AW'(cnt_q);
        wr_en    = busy_q && mask_q[SPAN-1];
        wr_data  = (op_q == OP_COPY) ? src_pix : color;
    end

    assign busy = busy_q;

    // R8: a launch never reaches the sequencer during an operation.
    a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);

    // R8: the step counter stays within the requested length.
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= len_q));

    // R8: an operation ends only after its last pixel.
    a_r8_done_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(cnt_q) == $past(len_q)));

    // R7: pixels are visited in ascending, wrapping order.
    a_r7_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |-> (wr_addr == PIX_AW'($past(wr_addr) + 1'b1)));
endmodule

// File: rtl/pix_engine.sv
// Top of the stipple and block-copy pixel engine. Wires the bus decoder,
// the pixel sequencer and the pixel store. Assumes 32-bit accesses only;
// reads return zero and are always ready.
module pix_engine
    import pe_pkg::*;
#(
    parameter int PIX_AW = 10,
    parameter int PIX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [23:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic [31:0]       bus_rdata,
    output logic              busy,
    input  logic [PIX_AW-1:0] dbg_addr,
    output logic [7:0]        dbg_pix
);
    logic              accept;
    logic [PIX_W-1:0]  color;
    logic              start;
    pe_op_e            op;
    logic [PIX_AW-1:0] dst;
    logic [PIX_AW-1:0] src;
    logic [LEN_W-1:0]  len_m1;
    logic [SPAN-1:0]   mask;
    logic              wr_en;
    logic [PIX_AW-1:0] wr_addr;
    logic [PIX_W-1:0]  wr_data;
    logic [PIX_AW-1:0] src_addr;
    logic [PIX_W-1:0]  src_pix;

    // Writes stall while an operation runs; reads never do.
    assign bus_ready = !(busy && bus_write);
    assign accept    = bus_valid && bus_write && bus_ready;
    assign bus_rdata = '0;

    pe_decode #(.PIX_AW(PIX_AW), .PIX_W(PIX_W)) i_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .color     (color),
        .start     (start),
        .op        (op),
        .dst       (dst),
        .src       (src),
        .len_m1    (len_m1),
        .mask      (mask)
    );

    pe_sequencer #(.PIX_AW(PIX_AW), .PIX_W(PIX_W)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (op),
        .dst      (dst),
        .src      (src),
        .len_m1   (len_m1),
        .mask     (mask),
        .color    (color),
        .src_pix  (src_pix),
        .busy     (busy),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .src_addr (src_addr)
    );

    pe_pixel_ram #(.PIX_AW(PIX_AW), .PIX_W(PIX_W)) i_ram (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_a_addr (src_addr),
        .rd_a_data (src_pix),
        .rd_b_addr (dbg_addr),
        .rd_b_data (dbg_pix)
    );

    // R9: a read never starts an operation.
    a_r9_read_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !busy) |=> !busy);
endmodule

// File: tb/test_pix_engine.sv
// Self-checking bench: a vector table of operations walked against a
// reference model, then directed tests for stall, reads and reset.
module test_pix_engine;
    localparam int PIX_AW = 10;
    localparam int DEPTH  = 1 << PIX_AW;

    typedef struct packed {
        logic        blk;
        logic [19:0] dst;
        logic [31:0] data;
        logic [31:0] color;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 20'd0,    32'hFFFF_FFFF, 32'h0000_0011, 8'd4},  // R4 full mask
        '{1'b0, 20'd40,   32'h8000_0001, 32'h0000_0022, 8'd4},  // R4 end bits
        '{1'b0, 20'd100,  32'hA5A5_0F0F, 32'h1234_5633, 8'd2},  // R2 low byte
        '{1'b1, 20'd200,  32'h07FF_FFFF, 32'h0000_0044, 8'd6},  // R6 fill 8
        '{1'b1, 20'd300,  32'h1F00_0000, 32'h0000_0000, 8'd5},  // R5 copy 32
        '{1'b1, 20'd201,  32'h0300_00C8, 32'h0000_0000, 8'd7},  // R7 overlap
        '{1'b0, 20'd1020, 32'hFFFF_FFFF, 32'h0000_0066, 8'd10}, // R10 dst wrap
        '{1'b1, 20'd500,  32'h0500_0FFE, 32'h0000_0000, 8'd10}, // R10 src wrap
        '{1'b1, 20'd2047, 32'h00FF_FFFF, 32'h0000_0077, 8'd3},  // R3 dst field
        '{1'b1, 20'd600,  32'h0000_0028, 32'h0000_0000, 8'd5}   // R5 length 1
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [23:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_ready;
    logic [31:0]       bus_rdata;
    logic              busy;
    logic [PIX_AW-1:0] dbg_addr = '0;
    logic [7:0]        dbg_pix;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [DEPTH];

    pix_engine #(.PIX_AW(PIX_AW)) i_pix_engine (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .busy(busy), .dbg_addr(dbg_addr), .dbg_pix(dbg_pix)
    );

    always #5 clk = ~clk;

    function automatic logic [23:0] mk_addr(logic blk, logic [19:0] dst, logic go);
        return {blk, dst, go, 2'b00};
    endfunction

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Issue one bus write from a negedge; returns at the negedge after acceptance.
    task automatic bus_wr(logic [23:0] a, logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        while (!bus_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    task automatic model_op(logic blk, logic [19:0] dst, logic [31:0] data, logic [7:0] col);
        int len;
        len = blk ? int'(data[28:24]) + 1 : 32;
        for (int i = 0; i < len; i++) begin
            int d;
            d = (int'(dst) + i) % DEPTH;
            if (!blk) begin
                if (data[31-i]) model[d] = col;
            end else if (data[23:0] == 24'hFFFFFF) begin
                model[d] = col;
            end else begin
                model[d] = model[(int'(data[23:0]) + i) % DEPTH];
            end
        end
    endtask

    task automatic check_mem(string req);
        int bad_a; logic [7:0] bad_v;
        bad_a = -1; bad_v = '0;
        for (int a = 0; a < DEPTH; a++) begin
            dbg_addr = PIX_AW'(a);
            #0.1;
            if (bad_a < 0 && dbg_pix != model[a]) begin bad_a = a; bad_v = dbg_pix; end
        end
        checks++;
        if (bad_a >= 0) begin
            errors++;
            $display("FAIL %s: pixel %0d actual %0h expected %0h", req, bad_a, bad_v, model[bad_a]);
        end
    endtask

    task automatic run_op(logic blk, logic [19:0] dst, logic [31:0] data, logic [31:0] col, output int n);
        bus_wr(mk_addr(blk, dst, 1'b0), col);
        bus_wr(mk_addr(blk, dst, 1'b1), data);
        wait_idle(n);
        model_op(blk, dst, data, col[7:0]);
    endtask

    initial begin
        #1_500_000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        for (int a = 0; a < DEPTH; a++) model[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk("R1 busy", busy, 0);
        chk("R1 ready", bus_ready, 1);

        // Clear the whole store with 32-pixel fills (R6).
        for (int k = 0; k < DEPTH / 32; k++) begin
            run_op(1'b1, 20'(k * 32), 32'h1FFF_FFFF, 32'h0, n);
        end
        check_mem("R6 clear");

        // Table walk: each operation against the model, with its duration.
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            run_op(VECS[v].blk, VECS[v].dst, VECS[v].data, VECS[v].color, n);
            tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
            check_mem(tag);
            chk($sformatf("R8 len vec%0d", v), n,
                VECS[v].blk ? int'(VECS[v].data[28:24]) + 1 : 32);
        end

        // R8: write during an operation is stalled, then accepted.
        bus_wr(mk_addr(1'b0, 20'd700, 1'b0), 32'h99);
        bus_wr(mk_addr(1'b0, 20'd700, 1'b1), 32'hFFFF_FFFF);
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr = mk_addr(1'b0, 20'd0, 1'b0); bus_wdata = 32'hAB;
        chk("R8 stall ready", bus_ready, 0);
        chk("R8 stall busy", busy, 1);
        while (!bus_ready) @(negedge clk);
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        model_op(1'b0, 20'd700, 32'hFFFF_FFFF, 8'h99);
        bus_wr(mk_addr(1'b1, 20'd750, 1'b1), 32'h01FF_FFFF);
        wait_idle(n);
        model_op(1'b1, 20'd750, 32'h01FF_FFFF, 8'hAB);
        check_mem("R8 stalled color");

        // R9: reads return zero, are ready and start nothing.
        bus_valid = 1'b1; bus_write = 1'b0;
        bus_addr = mk_addr(1'b1, 20'd10, 1'b1); bus_wdata = 32'h00FF_FFFF;
        #1;
        chk("R9 ready", bus_ready, 1);
        chk("R9 rdata", bus_rdata, 0);
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0;
        chk("R9 no busy", busy, 0);
        check_mem("R9 memory");

        // R1: reset clears the color but keeps the memory.
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        check_mem("R1 memory kept");
        bus_wr(mk_addr(1'b1, 20'd0, 1'b1), 32'h03FF_FFFF);
        wait_idle(n);
        model_op(1'b1, 20'd0, 32'h03FF_FFFF, 8'h00);
        check_mem("R1 color zero");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule